// File: doc/BRIEF.md
# Byte-Wide Bus Chip-Enable Decoder

This block sits between an 8051-style CPU and a separate byte-wide SRAM bus. Each cycle it takes a 16-bit CPU address, a flag telling whether the access is a program fetch or a data access, and read and write strobes. From these it produces registered, active-low chip enables, peripheral enables and a read/write line for the external memories and peripherals.

Program space and data space share one 17-bit linear memory. Program fetches use the CPU address directly. Data accesses are offset by a partition boundary, which is stored in 2 KB units. Everything below the boundary is program space and is write-protected.

The block supports two memory arrangements:
- four 32 KB devices, each with its own chip enable;
- one 128 KB device, where two of the enable pins carry the high address bits instead.

A peripheral-select input steers data accesses to four 16 KB peripheral windows instead of memory. Two supply flags control the outputs:
- a power-fail flag idles every output;
- a backup flag forces only the battery-backed outputs inactive.

Top module: `bytebus_decoder`

## Requirements
- R1: After reset, and one cycle after any cycle with neither `rd` nor `wr` high, `ce_n`, `ce1_raw_n` and `pe_n` read all ones and `rw_n` reads 1.
- R2: All outputs are registered. The inputs present at a rising clock edge appear on the outputs just after that edge, and not before.
- R3: A data access (`data_sel`=1) made while `pes`=1 drives exactly one `pe_n` bit low, selected by `addr[15:14]` (00→bit0, 01→bit1, 10→bit2, 11→bit3). All chip enables stay high. A program access ignores `pes`.
- R4: With `size_sel`=1 (four 32 KB devices), a memory access drives `ce_n[k]` low, where k = linear address bits [16:15].
- R5: With `size_sel`=0 (one 128 KB device), a memory access behaves as follows:
  - `ce_n[0]` goes low;
  - `ce_n[1]` carries linear bit 16;
  - `ce_n[2]` carries linear bit 15;
  - `ce_n[3]` stays high.
- R6: The linear address is formed as follows:
  - a program access uses `addr` zero-extended to 17 bits;
  - a data access uses (`part_q`×2048 + `addr`) modulo 2^17.
- R7: The partition register (6 bits, reset value 16) loads `part_in` on a clock edge only while `part_load` is 1. Otherwise it holds its value.
- R8: `rw_n` goes low only for a write to a peripheral, or for a data write whose linear address is at or above the partition base. Program-space writes, and data writes that wrap below the base, leave `rw_n` high.
- R9: While `backup` is 1, `ce_n[3:0]`, `pe_n[0]` and `pe_n[1]` are forced high. `pe_n[2]`, `pe_n[3]` and `ce1_raw_n` keep decoding normally.
- R10: While `pwr_fail` is 1, every enable output and `rw_n` is high one cycle later.
- R11: Among `ce_n[0]` and `pe_n`, at most one is low. In 32 KB mode, at most one of all `ce_n` and `pe_n` bits is low.
- R12: `ce1_raw_n` follows the decoded value of `ce_n[0]` without the backup forcing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | CPU address |
| data_sel | input | 1 | 1 = data access, 0 = program access |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| size_sel | input | 1 | 1 = four 32 KB devices, 0 = one 128 KB device |
| pes | input | 1 | Routes data accesses to peripheral enables |
| part_load | input | 1 | Allows the partition register to load |
| part_in | input | 6 | New partition boundary in 2 KB units |
| backup | input | 1 | Supply below backup threshold |
| pwr_fail | input | 1 | Supply below operating minimum |
| ce_n | output | 4 | Battery-backed chip enables (bits 1 and 2 carry address bits in 128 KB mode) |
| ce1_raw_n | output | 1 | Non-backed copy of chip enable 0 |
| pe_n | output | 4 | Peripheral enables; bits 0 and 1 are battery-backed |
| rw_n | output | 1 | Write enable, low for a write |

## Verification
A corrupted partition register can only be seen through the linear address. It shows up one cycle after the next data access, as the wrong chip enable or as a wrongly blocked or allowed write. Tests therefore place data addresses so that the old and new boundaries select different devices, and so that a write wraps below the base. A decode or forcing fault shows up on the very next registered cycle, as two enables low together or a backed enable low during backup.

// File: rtl/bytebus_decoder.sv
module bytebus_decoder #(
  parameter int AW = 16,
  parameter int GRAN_W = 11,
  localparam int LW = AW + 1,
  localparam int PW = LW - GRAN_W,
  parameter int PART_RESET = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          data_sel,
  input  logic          rd,
  input  logic          wr,
  input  logic          size_sel,
  input  logic          pes,
  input  logic          part_load,
  input  logic [PW-1:0] part_in,
  input  logic          backup,
  input  logic          pwr_fail,
  output logic [3:0]    ce_n,
  output logic          ce1_raw_n,
  output logic [3:0]    pe_n,
  output logic          rw_n
);

  logic [PW-1:0] part_q;
  logic [LW-1:0] base, lin;
  logic [1:0]    top;
  logic          req, is_pe, is_mem, wr_ok;
  logic [3:0]    ce_d, pe_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         part_q <= PW'(PART_RESET);
    else if (part_load) part_q <= part_in;

  assign base   = {part_q, {GRAN_W{1'b0}}};
  assign lin    = data_sel ? base + {1'b0, addr} : {1'b0, addr};
  assign top    = lin[LW-1:LW-2];
  assign req    = (rd | wr) & ~pwr_fail;
  assign is_pe  = req & data_sel & pes;
  assign is_mem = req & ~(data_sel & pes);
  assign wr_ok  = wr & ~pwr_fail & data_sel & (pes | (lin >= base));

  for (genvar i = 0; i < 4; i++) begin : g_pe
    assign pe_d[i] = ~(is_pe && addr[AW-1:AW-2] == 2'(i));
  end

  always_comb begin
    if (size_sel) begin
      for (int i = 0; i < 4; i++)
        ce_d[i] = ~(is_mem && top == 2'(i));
    end else begin
      ce_d[0] = ~is_mem;
      ce_d[1] = is_mem ? lin[LW-1] : 1'b1;
      ce_d[2] = is_mem ? lin[LW-2] : 1'b1;
      ce_d[3] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_n      <= '1;
      ce1_raw_n <= 1'b1;
      pe_n      <= '1;
      rw_n      <= 1'b1;
    end else begin
      ce_n      <= backup ? 4'hF : ce_d;
      ce1_raw_n <= ce_d[0];
      pe_n      <= {pe_d[3:2], backup ? 2'b11 : pe_d[1:0]};
      rw_n      <= ~wr_ok;
    end

endmodule

module bytebus_decoder_chk #(parameter int PW = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd,
  input logic          wr,
  input logic          data_sel,
  input logic          size_sel,
  input logic          backup,
  input logic          pwr_fail,
  input logic          part_load,
  input logic [PW-1:0] part_q,
  input logic [3:0]    ce_n,
  input logic          ce1_raw_n,
  input logic [3:0]    pe_n,
  input logic          rw_n
);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd && !wr) |-> (ce_n == 4'hF && pe_n == 4'hF && ce1_raw_n && rw_n));
  a_r10_pwr_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_fail) |-> (ce_n == 4'hF && pe_n == 4'hF && ce1_raw_n && rw_n));
  a_r9_backup: assert property (@(posedge clk) disable iff (!rst_n)
    $past(backup) |-> (ce_n == 4'hF && pe_n[1:0] == 2'b11));
  a_r8_prog_wp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!data_sel || !wr) |-> rw_n);
  a_r11_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ce_n[0], ~pe_n}));
  a_r11_one_hot_32k: assert property (@(posedge clk) disable iff (!rst_n)
    $past(size_sel) |-> $onehot0({~ce_n, ~pe_n}));
  a_r5_ce4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!size_sel) |-> ce_n[3]);
  a_r7_part_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!part_load) |-> $stable(part_q));
endmodule

bind bytebus_decoder bytebus_decoder_chk #(.PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .data_sel(data_sel),
  .size_sel(size_sel), .backup(backup), .pwr_fail(pwr_fail),
  .part_load(part_load), .part_q(part_q), .ce_n(ce_n),
  .ce1_raw_n(ce1_raw_n), .pe_n(pe_n), .rw_n(rw_n));

// File: tb/bytebus_decoder_test.sv
module bytebus_decoder_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] addr = '0;
  logic data_sel = 0, rd = 0, wr = 0, size_sel = 1, pes = 0;
  logic part_load = 0, backup = 0, pwr_fail = 0;
  logic [5:0] part_in = '0;
  logic [3:0] ce_n, pe_n;
  logic ce1_raw_n, rw_n;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bytebus_decoder uut (.clk(clk), .rst_n(rst_n), .addr(addr), .data_sel(data_sel),
    .rd(rd), .wr(wr), .size_sel(size_sel), .pes(pes), .part_load(part_load),
    .part_in(part_in), .backup(backup), .pwr_fail(pwr_fail), .ce_n(ce_n),
    .ce1_raw_n(ce1_raw_n), .pe_n(pe_n), .rw_n(rw_n));

  function automatic logic [9:0] pk(logic raw, logic [3:0] ce, logic [3:0] pe, logic rw);
    return {raw, ce, pe, rw};
  endfunction

  localparam logic [9:0] IDLE = 10'b1_1111_1111_1;

  task automatic chk(string req, logic [9:0] exp);
    logic [9:0] act = {ce1_raw_n, ce_n, pe_n, rw_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic go(logic ds, logic r, logic w, logic [15:0] a);
    @(negedge clk); data_sel = ds; rd = r; wr = w; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk); rd = 0; wr = 0;
    @(posedge clk); #1;
  endtask

  task automatic load_part(logic [5:0] v);
    @(negedge clk); part_in = v; part_load = 1;
    @(negedge clk); part_load = 0;
  endtask

  task automatic t_reset();
    #1 chk("R1 reset", IDLE);
    idle(); chk("R1 idle", IDLE);
  endtask

  task automatic t_32k();
    size_sel = 1;
    @(negedge clk); data_sel = 0; rd = 1; addr = 16'h1234;
    #1 chk("R2 before edge", IDLE);
    @(posedge clk); #1 chk("R4 R6 prog 0x1234 -> ce0", pk(0, 4'b1110, 4'hF, 1));
    go(1, 1, 0, 16'h0010); chk("R4 R6 data 0x0010 -> ce1", pk(1, 4'b1101, 4'hF, 1));
    go(1, 1, 0, 16'h9000); chk("R4 R6 data 0x9000 -> ce2", pk(1, 4'b1011, 4'hF, 1));
    idle(); chk("R2 R1 back to idle", IDLE);
    load_part(6'd40);
    go(1, 1, 0, 16'h5000); chk("R7 R6 base 40 data 0x5000 -> ce3", pk(1, 4'b0111, 4'hF, 1));
    idle();
    @(negedge clk); part_in = 6'd8; part_load = 0;
    go(1, 1, 0, 16'h0000); chk("R7 no load keeps base 40 -> ce2", pk(1, 4'b1011, 4'hF, 1));
    idle();
    load_part(6'd16);
  endtask

  task automatic t_128k();
    size_sel = 0;
    go(0, 1, 0, 16'hC000); chk("R5 prog 0xC000 A16=0 A15=1", pk(0, 4'b1100, 4'hF, 1));
    go(1, 1, 0, 16'h9000); chk("R5 data 0x9000 A16=1 A15=0", pk(0, 4'b1010, 4'hF, 1));
    idle(); chk("R1 128k idle", IDLE);
    size_sel = 1;
  endtask

  task automatic t_periph();
    pes = 1;
    go(1, 1, 0, 16'h4100); chk("R3 pe1 window", pk(1, 4'hF, 4'b1101, 1));
    go(1, 1, 0, 16'hC000); chk("R3 pe3 window", pk(1, 4'hF, 4'b0111, 1));
    go(0, 1, 0, 16'h0000); chk("R3 program ignores pes", pk(0, 4'b1110, 4'hF, 1));
    pes = 0; idle();
  endtask

  task automatic t_write();
    go(0, 0, 1, 16'h0100); chk("R8 program write blocked", pk(0, 4'b1110, 4'hF, 1));
    go(1, 0, 1, 16'h0100); chk("R8 data write allowed", pk(1, 4'b1101, 4'hF, 0));
    idle();
    load_part(6'd40);
    go(1, 0, 1, 16'hF000); chk("R8 R6 wrapped write blocked", pk(0, 4'b1110, 4'hF, 1));
    idle();
    load_part(6'd16);
    pes = 1;
    go(1, 0, 1, 16'h0000); chk("R8 peripheral write", pk(1, 4'hF, 4'b1110, 0));
    pes = 0; idle();
  endtask

  task automatic t_backup();
    backup = 1;
    go(0, 1, 0, 16'h0000); chk("R9 R12 backup ce forced, raw live", pk(0, 4'hF, 4'hF, 1));
    pes = 1;
    go(1, 1, 0, 16'h8000); chk("R9 pe2 not backed", pk(1, 4'hF, 4'b1011, 1));
    go(1, 1, 0, 16'h0000); chk("R9 pe0 forced", IDLE);
    go(1, 1, 0, 16'h4000); chk("R9 pe1 forced", IDLE);
    pes = 0; backup = 0;
    go(0, 1, 0, 16'h0000); chk("R12 normal raw equals ce0", pk(0, 4'b1110, 4'hF, 1));
    idle();
  endtask

  task automatic t_pwr_fail();
    pwr_fail = 1;
    go(1, 0, 1, 16'h0100); chk("R10 write idled", IDLE);
    pes = 1;
    go(1, 1, 0, 16'hC000); chk("R10 peripheral idled", IDLE);
    pes = 0; pwr_fail = 0; idle();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    t_reset();
    t_32k();
    t_128k();
    t_periph();
    t_write();
    t_backup();
    t_pwr_fail();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule